// File: doc/BRIEF.md
# UART DMA Request Pin Generator

This block produces the two active-low DMA request pins of a UART channel: a receive-side request (`rx_req_n`) that tells a DMA engine characters are waiting, and a transmit-side request (`tx_req_n`) that tells it space is free. It watches the occupancy counts of the receive and transmit FIFOs, a receive timeout pulse, and three control inputs: the FIFO enable, the DMA burst select and the two-bit receive trigger select. It also decodes that trigger select into a numeric receive threshold.

Two transfer styles are supported. Single-transfer style applies when the FIFOs are off, or when they are on but burst is not selected. Each request then simply follows "something is there" or "nothing is there". Burst style applies when the FIFOs are on and burst is selected. Each request then has a set condition and a separate release condition, held in a flag register. Receive requests are raised at the trigger level or on a timeout and are dropped only once the FIFO is empty. Transmit requests are raised on an empty FIFO, or on enough free space, and are dropped only once the FIFO is full. A parameter selects the 16-entry or the 64-entry configuration. This choice changes the threshold table and the transmit burst set rule.

Top module: `uart_dma_ready`

## Requirements
- R1: While reset is high, both request pins are driven high (inactive) from the first clock edge of reset, and both request flags are cleared.
- R2: In the 16-entry configuration, `rx_trig_level` is a combinational decode of `rx_trig_sel`: code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 14.
- R3: In the 64-entry configuration, the decode is: code 0 gives 8, code 1 gives 16, code 2 gives 56, code 3 gives 60.
- R4: In single-transfer style (`fifo_en`=0, or `fifo_en`=1 with `dma_burst`=0), `rx_req_n` is 0 one clock after `rx_count` is nonzero and 1 one clock after it is zero.
- R5: In single-transfer style, `tx_req_n` is 0 one clock after `tx_count` is zero and 1 one clock after it is nonzero.
- R6: In burst style, `rx_req_n` falls one clock after `rx_count` equals `rx_trig_level`.
- R7: In burst style, a `rx_timeout` pulse with `rx_count` nonzero makes `rx_req_n` fall one clock later. A pulse while `rx_count` is zero has no effect, and the pin stays 1.
- R8: In burst style, once `rx_req_n` is low it stays low while `rx_count` falls below the trigger level, and it returns to 1 one clock after `rx_count` is zero.
- R9: In burst style with 16 entries, `tx_req_n` falls one clock after `tx_count` is zero. It stays low while data is refilled, returns to 1 one clock after `tx_count` equals 16, and does not fall again on a partial drain.
- R10: In burst style with 64 entries, `tx_req_n` falls one clock after (64 − `tx_count`) is strictly greater than `tx_free_thresh`. It stays low until one clock after `tx_count` equals 64. `tx_free_thresh` must be below the depth.
- R11: In burst style, a receive count above the trigger level that was never equal to it, with no timeout, does not raise the receive request.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable control bit |
| dma_burst | input | 1 | DMA burst-style select bit |
| rx_trig_sel | input | 2 | Receive trigger select code |
| rx_count | input | CW | Receive FIFO occupancy, CW = clog2(DEPTH+1) |
| tx_count | input | CW | Transmit FIFO occupancy |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| tx_free_thresh | input | CW | Free-space threshold for the 64-entry burst transmit rule |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |
| rx_trig_level | output | CW | Decoded receive trigger threshold |

## Verification
The decoded threshold is combinational, so it is due in the same cycle that the select changes. The bench compares it one nanosecond after driving the inputs. Both request pins pass through one flag register each, so a pin reflects the inputs applied before the next rising edge and is due after that edge. The driver tags every expected pin pair with the cycle number at which it falls due. The monitor compares only at falling edges where the current cycle has reached that tag, which keeps the next stimulus from racing the comparison. Both configurations are instantiated side by side so that each threshold table and each transmit burst rule is covered.

// File: rtl/uart_dma_ready_pkg.sv
package uart_dma_ready_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BURST  = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic       fifo_en;
        logic       dma_burst;
        logic [1:0] trig_sel;
    } dma_ctrl_t;

    // Burst style only when FIFOs are on and burst is selected.
    function automatic xfer_mode_e mode_of(input dma_ctrl_t c);
        return (c.fifo_en && c.dma_burst) ? XFER_BURST : XFER_SINGLE;
    endfunction

    // Receive threshold table for the small (16) or large (64) configuration.
    function automatic int unsigned trig_level(input logic [1:0] sel, input bit big);
        int unsigned lvl;
        if (big) begin
            case (sel)
                2'd0:    lvl = 8;
                2'd1:    lvl = 16;
                2'd2:    lvl = 56;
                default: lvl = 60;
            endcase
        end else begin
            case (sel)
                2'd0:    lvl = 1;
                2'd1:    lvl = 4;
                2'd2:    lvl = 8;
                default: lvl = 14;
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/uart_dma_trig_decode.sv
module uart_dma_trig_decode
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] level
);
    localparam bit BIG = (DEPTH >= 64);

    always_comb begin
        level = CW'(trig_level(sel, BIG));
    end

    // R2 / R3: a decoded level is never zero and never reaches the depth.
    always_comb begin
        assert_level_range_R2: assert (level != '0 && int'(level) < DEPTH);
    end

endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
    import uart_dma_ready_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] level,
    input  logic          timeout,
    output logic          req
);
    logic nonempty;
    logic hit;
    logic req_q;
    logic req_d;

    assign nonempty = (rx_count != '0);
    assign hit      = (rx_count == level) || timeout;

    // Single: follow occupancy. Burst: set on trigger/timeout, hold until empty.
    always_comb begin
        if (mode == XFER_BURST) req_d = nonempty && (req_q || hit);
        else                    req_d = nonempty;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_d;
    end

    assign req = req_q;

    // R8: an empty receive FIFO drops the request on the next edge, any mode.
    assert_empty_release_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |=> !req_q);

    // R8: a burst request with data left is held across the next edge.
    assert_burst_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_BURST && req_q && rx_count != '0) |=> req_q);

    // R6: the trigger level in burst style raises the request.
    assert_trigger_set_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_BURST && rx_count == level && rx_count != '0) |=> req_q);

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] free_thresh,
    output logic          req
);
    localparam bit BIG = (DEPTH >= 64);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic empty;
    logic full;
    logic burst_start;
    logic req_q;
    logic req_d;

    assign empty = (tx_count == '0);
    assign full  = (tx_count == FULL);

    generate
        if (BIG) begin : g_free_rule
            logic [CW-1:0] free_slots;
            assign free_slots  = FULL - tx_count;
            assign burst_start = (free_slots > free_thresh);
        end else begin : g_empty_rule
            assign burst_start = empty;
        end
    endgenerate

    // Single: follow emptiness. Burst: set on the start rule, hold until full.
    always_comb begin
        if (mode == XFER_BURST) req_d = !full && (req_q || burst_start);
        else                    req_d = empty;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_d;
    end

    assign req = req_q;

    // R9 / R10: a full transmit FIFO drops the request on the next edge.
    assert_full_release_R9: assert property (@(posedge clk) disable iff (rst)
        full |=> !req_q);

    // R5: single style, an empty FIFO raises the request on the next edge.
    assert_single_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_SINGLE && empty) |=> req_q);

    // R10: the free-space threshold must stay below the depth.
    always_comb begin
        assert_thresh_range_R10: assert (int'(free_thresh) < DEPTH);
    end

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          dma_burst,
    input  logic [1:0]    rx_trig_sel,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_timeout,
    input  logic [CW-1:0] tx_free_thresh,
    output logic          rx_req_n,
    output logic          tx_req_n,
    output logic [CW-1:0] rx_trig_level
);
    dma_ctrl_t  ctrl;
    xfer_mode_e mode;
    logic       rx_req;
    logic       tx_req;

    assign ctrl = '{fifo_en: fifo_en, dma_burst: dma_burst, trig_sel: rx_trig_sel};
    assign mode = mode_of(ctrl);

    uart_dma_trig_decode #(.DEPTH(DEPTH)) u_decode (
        .sel   (ctrl.trig_sel),
        .level (rx_trig_level)
    );

    uart_dma_rx_req #(.CW(CW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .rx_count (rx_count),
        .level    (rx_trig_level),
        .timeout  (rx_timeout),
        .req      (rx_req)
    );

    uart_dma_tx_req #(.DEPTH(DEPTH)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .tx_count    (tx_count),
        .free_thresh (tx_free_thresh),
        .req         (tx_req)
    );

    assign rx_req_n = ~rx_req;
    assign tx_req_n = ~tx_req;

    // R1: reset leaves both pins inactive after its first edge.
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rx_req_n && tx_req_n));

endmodule

// File: tb/uart_dma_ready_test.sv
module uart_dma_ready_test;

    typedef struct {
        int    inst;
        int    due;
        logic  exp_rx;
        logic  exp_tx;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_item_t q[$];

    // 16-entry instance signals
    logic       en16 = 0, b16 = 0, to16 = 0;
    logic [1:0] sel16 = 0;
    logic [4:0] rx16 = 0, tx16 = 0, thr16 = 0, lvl16;
    logic       rxn16, txn16;

    // 64-entry instance signals
    logic       en64 = 0, b64 = 0, to64 = 0;
    logic [1:0] sel64 = 0;
    logic [6:0] rx64 = 0, tx64 = 0, thr64 = 7'd20, lvl64;
    logic       rxn64, txn64;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    uart_dma_ready #(.DEPTH(16)) uut (
        .clk(clk), .rst(rst), .fifo_en(en16), .dma_burst(b16),
        .rx_trig_sel(sel16), .rx_count(rx16), .tx_count(tx16),
        .rx_timeout(to16), .tx_free_thresh(thr16),
        .rx_req_n(rxn16), .tx_req_n(txn16), .rx_trig_level(lvl16)
    );

    uart_dma_ready #(.DEPTH(64)) uut64 (
        .clk(clk), .rst(rst), .fifo_en(en64), .dma_burst(b64),
        .rx_trig_sel(sel64), .rx_count(rx64), .tx_count(tx64),
        .rx_timeout(to64), .tx_free_thresh(thr64),
        .rx_req_n(rxn64), .tx_req_n(txn64), .rx_trig_level(lvl64)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver for the 16-entry instance: level checked now, pins queued for next edge.
    task automatic step16(input logic en, input logic b, input logic [1:0] sel,
                          input int rxc, input int txc, input logic to,
                          input logic erx, input logic etx, input int elvl,
                          input string tag);
        exp_item_t it;
        @(posedge clk);
        #1;
        en16 = en; b16 = b; sel16 = sel; rx16 = 5'(rxc); tx16 = 5'(txc); to16 = to;
        #1;
        check({tag, " level16"}, int'(lvl16), elvl);
        it.inst = 16; it.due = cyc + 1; it.exp_rx = erx; it.exp_tx = etx; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step64(input logic en, input logic b, input logic [1:0] sel,
                          input int rxc, input int txc, input int thr, input logic to,
                          input logic erx, input logic etx, input int elvl,
                          input string tag);
        exp_item_t it;
        @(posedge clk);
        #1;
        en64 = en; b64 = b; sel64 = sel; rx64 = 7'(rxc); tx64 = 7'(txc);
        thr64 = 7'(thr); to64 = to;
        #1;
        check({tag, " level64"}, int'(lvl64), elvl);
        it.inst = 64; it.due = cyc + 1; it.exp_rx = erx; it.exp_tx = etx; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares queued pin expectations once their cycle has come.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_item_t it;
            it = q.pop_front();
            if (it.inst == 16) begin
                check({it.tag, " rx_req_n"}, int'(rxn16), int'(it.exp_rx));
                check({it.tag, " tx_req_n"}, int'(txn16), int'(it.exp_tx));
            end else begin
                check({it.tag, " rx_req_n"}, int'(rxn64), int'(it.exp_rx));
                check({it.tag, " tx_req_n"}, int'(txn64), int'(it.exp_tx));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rx16", int'(rxn16), 1);
        check("R1 reset tx16", int'(txn16), 1);
        check("R1 reset rx64", int'(rxn64), 1);
        check("R1 reset tx64", int'(txn64), 1);
        rst = 1'b0;

        // 16-entry: single-transfer style
        step16(0, 0, 2'd0, 0, 0, 0, 1, 0, 1,  "R5 R2 single empty");
        step16(0, 0, 2'd0, 3, 2, 0, 0, 1, 1,  "R4 R5 single data");
        step16(0, 0, 2'd1, 0, 2, 0, 1, 1, 4,  "R4 R2 single rx empty");
        step16(1, 0, 2'd2, 1, 0, 0, 0, 0, 8,  "R4 R5 fifo non-burst");
        step16(1, 0, 2'd3, 0, 5, 0, 1, 1, 14, "R2 code3");
        // 16-entry: burst receive
        step16(1, 1, 2'd1, 1, 5, 0, 1, 1, 4,  "R11 below trigger");
        step16(1, 1, 2'd1, 3, 5, 0, 1, 1, 4,  "R11 below trigger 3");
        step16(1, 1, 2'd1, 4, 5, 0, 0, 1, 4,  "R6 trigger hit");
        step16(1, 1, 2'd1, 2, 5, 0, 0, 1, 4,  "R8 hold 2");
        step16(1, 1, 2'd1, 1, 5, 0, 0, 1, 4,  "R8 hold 1");
        step16(1, 1, 2'd1, 0, 5, 0, 1, 1, 4,  "R8 release empty");
        step16(1, 1, 2'd1, 6, 5, 0, 1, 1, 4,  "R11 jumped past");
        step16(1, 1, 2'd1, 6, 5, 1, 0, 1, 4,  "R7 timeout set");
        step16(1, 1, 2'd1, 0, 5, 0, 1, 1, 4,  "R8 release after timeout");
        step16(1, 1, 2'd1, 0, 5, 1, 1, 1, 4,  "R7 timeout on empty ignored");
        // 16-entry: burst transmit
        step16(1, 1, 2'd1, 0, 0,  0, 1, 0, 4, "R9 tx empty set");
        step16(1, 1, 2'd1, 0, 9,  0, 1, 0, 4, "R9 hold 9");
        step16(1, 1, 2'd1, 0, 15, 0, 1, 0, 4, "R9 hold 15");
        step16(1, 1, 2'd1, 0, 16, 0, 1, 1, 4, "R9 full release");
        step16(1, 1, 2'd1, 0, 10, 0, 1, 1, 4, "R9 partial no reassert");

        // 64-entry
        step64(0, 0, 2'd0, 0, 0,  20, 0, 1, 0, 8,  "R3 code0 single");
        step64(0, 0, 2'd1, 2, 3,  20, 0, 0, 1, 16, "R3 code1 R4");
        step64(0, 0, 2'd2, 0, 3,  20, 0, 1, 1, 56, "R3 code2");
        step64(1, 1, 2'd3, 59, 50, 20, 0, 1, 1, 60, "R3 code3 R10 free14");
        step64(1, 1, 2'd3, 60, 44, 20, 0, 0, 1, 60, "R6 R10 free20 boundary");
        step64(1, 1, 2'd3, 60, 43, 20, 0, 0, 0, 60, "R10 free21 set");
        step64(1, 1, 2'd3, 60, 63, 20, 0, 0, 0, 60, "R10 hold");
        step64(1, 1, 2'd3, 60, 64, 20, 0, 0, 1, 60, "R10 full release");
        step64(1, 1, 2'd3, 0, 64,  20, 0, 1, 1, 60, "R8 rx64 release");

        repeat (3) @(posedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL drain: actual %0d expected 0 pending", q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule